// File: doc/BRIEF.md
# Vector-Scalar Compare Predicate Unit

This unit compares every lane of a 128-bit vector operand against a single scalar taken from a 32-bit general-purpose register. A size code chooses the lane width: 16 lanes of 8 bits, 8 lanes of 16 bits, or 4 lanes of 32 bits. A three-bit selector picks one of eight conditions. Each lane produces one result bit. That bit is copied across all the bytes the lane covers, which gives a 16-bit predicate with one bit per byte.

The per-byte result is first gated by an active-lane mask. It is then merged into a held predicate register, and only the byte positions enabled by a beat-update mask are replaced. The index of the scalar register travels with the request. Index 15 stands for the constant zero, and index 13 is rejected. When a nonzero predication mask comes with a legal request, the unit also raises a one-cycle strobe that opens a predicated block, and it presents that mask beside the strobe. All results are registered: they appear on the clock edge that accepts the request.

Top module: `vscmp_pred_unit`

## Requirements
- R1: Size code 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Lane k of width B bytes drives predicate bits k*B through k*B+B-1, with lane 0 at the least significant bits, and all of those bits carry the same value.
- R2: A request with size code 3 sets the illegal flag for one cycle and leaves the predicate unchanged.
- R3: Only the low lane-width bits of the scalar are compared; the scalar bits above the lane width have no effect.
- R4: With selector bit 2 clear, the lanes are compared unsigned. Selector {b2,b1,b0} = 000 is EQ, 010 is NE, 001 is lane >= scalar and 011 is lane > scalar.
- R5: With selector bit 2 set, the lanes are compared as two's-complement values. Selector 100 is GE, 110 is LT, 101 is GT and 111 is LE.
- R6: A per-byte result whose active-lane mask bit is 0 is written as 0.
- R7: Only predicate bits whose beat-update mask bit is 1 are replaced. Every other bit keeps its previous value.
- R8: A scalar index of 15 makes the scalar value zero, whatever is on the scalar input.
- R9: A scalar index of 13 sets the illegal flag for one cycle and leaves the predicate unchanged.
- R10: A legal request with a nonzero block mask raises blk_start_q for one cycle, and blk_mask_q carries that mask. A legal request with a zero block mask leaves blk_start_q low.
- R11: Results appear on the clock edge that accepts req_valid. In a cycle without a request the predicate holds, and illegal_q and blk_start_q are low.
- R12: Driving rst_n low clears the predicate, the illegal flag and the block strobe at once. They stay cleared until the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| req_valid | input | 1 | Compare request for this cycle |
| vec_in | input | 128 | Vector operand, byte 0 in bits 7:0 |
| scalar_in | input | 32 | Value read from the scalar register |
| scalar_idx | input | 4 | Index of the scalar register (15 = zero, 13 = illegal) |
| size_code | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: illegal) |
| cond_sel | input | 3 | Condition select {group, b1, b0} |
| lane_mask | input | 16 | Active-lane mask, one bit per byte |
| beat_mask | input | 16 | Beat-update mask, one bit per predicate bit |
| block_mask | input | 4 | Predication-block mask; zero means a plain compare |
| pred_q | output | 16 | Predicate register |
| illegal_q | output | 1 | One-cycle flag for a rejected request |
| blk_start_q | output | 1 | One-cycle strobe that opens a predicated block |
| blk_mask_q | output | 4 | Mask accompanying blk_start_q |

## Verification
The hardest case to reach is a partial update. A compare that changes only some predicate bits can only be seen against a known predicate that is not all zero, and after reset the predicate is all zero. The stimulus therefore first loads an all-ones predicate with an NE compare that matches no lane. It then issues the beat-masked request, the lane-masked request and the two illegal requests (index 13 and size code 3), so that any stray write would show up as a flipped bit. The vector table uses lane values on both sides of the signed and unsigned boundaries, such as 0x8000, 0x7fff and 0xffff, so that the unsigned and signed condition groups give different results on the same operand.

// File: rtl/vscmp_pkg.sv
package vscmp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  // Condition decoded into primitive terms:
  // hit = invert ^ ((take_eq & eq) | (take_gt & gt))
  typedef struct packed {
    logic is_signed;
    logic take_eq;
    logic take_gt;
    logic invert;
  } cond_dec_t;

  function automatic cond_dec_t decode_cond(input logic [2:0] sel);
    cond_dec_t d;
    logic [2:0] terms;
    case (sel)
      3'b000:  terms = 3'b100; // equal
      3'b010:  terms = 3'b101; // not equal
      3'b001:  terms = 3'b110; // unsigned >=
      3'b011:  terms = 3'b010; // unsigned >
      3'b100:  terms = 3'b110; // signed >=
      3'b110:  terms = 3'b111; // signed <
      3'b101:  terms = 3'b010; // signed >
      default: terms = 3'b011; // signed <=
    endcase
    d.is_signed = sel[2];
    d.take_eq   = terms[2];
    d.take_gt   = terms[1];
    d.invert    = terms[0];
    return d;
  endfunction

endpackage

// File: rtl/vscmp_lane_cmp.sv
module vscmp_lane_cmp
  import vscmp_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] scalar_b,
  input  cond_dec_t         dec,
  output logic              hit
);

  logic eq;
  logic gt_u;
  logic gt_s;
  logic gt;

  always_comb begin
    eq   = (lane_a == scalar_b);
    gt_u = (lane_a > scalar_b);
    gt_s = ($signed(lane_a) > $signed(scalar_b));
    gt   = dec.is_signed ? gt_s : gt_u;
    hit  = dec.invert ^ ((dec.take_eq & eq) | (dec.take_gt & gt));
  end

endmodule

// File: rtl/vscmp_size_slice.sv
module vscmp_size_slice
  import vscmp_pkg::*;
#(
  parameter int VEC_BYTES  = 16,
  parameter int LANE_BYTES = 1
) (
  input  logic [VEC_BYTES*8-1:0]  vec,
  input  logic [LANE_BYTES*8-1:0] scalar_t,
  input  cond_dec_t               dec,
  output logic [VEC_BYTES-1:0]    byte_hits
);

  localparam int LANE_W = LANE_BYTES * 8;
  localparam int LANES  = VEC_BYTES / LANE_BYTES;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_hit;

    vscmp_lane_cmp #(
      .LANE_W (LANE_W)
    ) u_cmp (
      .lane_a   (vec[k*LANE_W +: LANE_W]),
      .scalar_b (scalar_t),
      .dec      (dec),
      .hit      (lane_hit)
    );

    assign byte_hits[k*LANE_BYTES +: LANE_BYTES] = {LANE_BYTES{lane_hit}};
  end

endmodule

// File: rtl/vscmp_pred_merge.sv
module vscmp_pred_merge #(
  parameter int PRED_W = 16
) (
  input  logic [PRED_W-1:0] pred_cur,
  input  logic [PRED_W-1:0] raw_hits,
  input  logic [PRED_W-1:0] lane_mask,
  input  logic [PRED_W-1:0] beat_mask,
  output logic [PRED_W-1:0] pred_nxt
);

  logic [PRED_W-1:0] gated;

  always_comb begin
    gated    = raw_hits & lane_mask;
    pred_nxt = (pred_cur & ~beat_mask) | (gated & beat_mask);
  end

endmodule

// File: rtl/vscmp_pred_unit.sv
module vscmp_pred_unit
  import vscmp_pkg::*;
#(
  parameter int VEC_BYTES  = 16,
  parameter int SCALAR_W   = 32,
  parameter int IDX_W      = 4,
  parameter int ZERO_IDX   = 15,
  parameter int BAD_IDX    = 13,
  parameter int BLK_MASK_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VEC_BYTES*8-1:0] vec_in,
  input  logic [SCALAR_W-1:0]    scalar_in,
  input  logic [IDX_W-1:0]       scalar_idx,
  input  logic [1:0]             size_code,
  input  logic [2:0]             cond_sel,
  input  logic [VEC_BYTES-1:0]   lane_mask,
  input  logic [VEC_BYTES-1:0]   beat_mask,
  input  logic [BLK_MASK_W-1:0]  block_mask,
  output logic [VEC_BYTES-1:0]   pred_q,
  output logic                   illegal_q,
  output logic                   blk_start_q,
  output logic [BLK_MASK_W-1:0]  blk_mask_q
);

  localparam int PRED_W  = VEC_BYTES;
  localparam int N_SIZES = 3;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Operand selection and legality
  logic [SCALAR_W-1:0] scalar_eff;
  logic                op_legal;
  cond_dec_t           dec;

  always_comb begin
    scalar_eff = (scalar_idx == IDX_W'(ZERO_IDX)) ? '0 : scalar_in;
    op_legal   = (size_code != SZ_BAD) && (scalar_idx != IDX_W'(BAD_IDX));
    dec        = decode_cond(cond_sel);
  end

  // One compare slice per lane width
  logic [PRED_W-1:0] hits_by_size [N_SIZES];

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int LB = 1 << s;
    vscmp_size_slice #(
      .VEC_BYTES  (VEC_BYTES),
      .LANE_BYTES (LB)
    ) u_slice (
      .vec       (vec_in),
      .scalar_t  (scalar_eff[LB*8-1:0]),
      .dec       (dec),
      .byte_hits (hits_by_size[s])
    );
  end

  logic [PRED_W-1:0] raw_hits;

  always_comb begin
    case (size_code)
      SZ_HALF: raw_hits = hits_by_size[1];
      SZ_WORD: raw_hits = hits_by_size[2];
      default: raw_hits = hits_by_size[0];
    endcase
  end

  logic [PRED_W-1:0] pred_merged;

  vscmp_pred_merge #(
    .PRED_W (PRED_W)
  ) u_merge (
    .pred_cur  (pred_q),
    .raw_hits  (raw_hits),
    .lane_mask (lane_mask),
    .beat_mask (beat_mask),
    .pred_nxt  (pred_merged)
  );

  // Next state
  logic [PRED_W-1:0]     pred_d;
  logic                  pred_en;
  logic                  illegal_d;
  logic                  blk_start_d;
  logic [BLK_MASK_W-1:0] blk_mask_d;
  logic                  blk_en;

  always_comb begin
    pred_en     = req_valid && op_legal;
    pred_d      = pred_merged;
    illegal_d   = req_valid && !op_legal;
    blk_en      = pred_en;
    blk_mask_d  = block_mask;
    blk_start_d = pred_en && (block_mask != '0);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   pred_q <= '0;
    else if (pred_en) pred_q <= pred_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      illegal_q   <= 1'b0;
      blk_start_q <= 1'b0;
    end else begin
      illegal_q   <= illegal_d;
      blk_start_q <= blk_start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  blk_mask_q <= '0;
    else if (blk_en) blk_mask_q <= blk_mask_d;
  end

endmodule

// File: rtl/vscmp_pred_unit_chk.sv
module vscmp_pred_unit_chk #(
  parameter int VEC_BYTES  = 16,
  parameter int IDX_W      = 4,
  parameter int BAD_IDX    = 13,
  parameter int BLK_MASK_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [IDX_W-1:0]      scalar_idx,
  input logic [1:0]            size_code,
  input logic [VEC_BYTES-1:0]  lane_mask,
  input logic [VEC_BYTES-1:0]  beat_mask,
  input logic [BLK_MASK_W-1:0] block_mask,
  input logic [VEC_BYTES-1:0]  pred_q,
  input logic                  illegal_q,
  input logic                  blk_start_q,
  input logic [BLK_MASK_W-1:0] blk_mask_q
);

  logic good_req;
  assign good_req = req_valid && (size_code != 2'd3) && (scalar_idx != IDX_W'(BAD_IDX));

  assert_halfword_replicate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    good_req && size_code == 2'd1 && (&lane_mask) && (&beat_mask)
    |=> ((((pred_q >> 1) ^ pred_q) & {(VEC_BYTES/2){2'b01}}) == '0));

  assert_word_replicate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    good_req && size_code == 2'd2 && (&lane_mask) && (&beat_mask)
    |=> ((((pred_q >> 1) ^ pred_q) & {(VEC_BYTES/4){4'b0111}}) == '0));

  // R2 and R9: a rejected request flags and leaves the predicate alone
  assert_illegal_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !good_req |=> illegal_q && $stable(pred_q) && !blk_start_q);

  assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good_req |=> ((pred_q & $past(beat_mask) & ~$past(lane_mask)) == '0));

  assert_beat_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (((pred_q ^ $past(pred_q)) & ~$past(beat_mask)) == '0));

  assert_block_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    good_req && (block_mask != '0) |=> blk_start_q && (blk_mask_q == $past(block_mask)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(pred_q) && !illegal_q && !blk_start_q);

endmodule

bind vscmp_pred_unit vscmp_pred_unit_chk #(
  .VEC_BYTES  (VEC_BYTES),
  .IDX_W      (IDX_W),
  .BAD_IDX    (BAD_IDX),
  .BLK_MASK_W (BLK_MASK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .scalar_idx  (scalar_idx),
  .size_code   (size_code),
  .lane_mask   (lane_mask),
  .beat_mask   (beat_mask),
  .block_mask  (block_mask),
  .pred_q      (pred_q),
  .illegal_q   (illegal_q),
  .blk_start_q (blk_start_q),
  .blk_mask_q  (blk_mask_q)
);

// File: tb/vscmp_pred_unit_tb.sv
module vscmp_pred_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [127:0] vec_in;
  logic [31:0]  scalar_in;
  logic [3:0]   scalar_idx;
  logic [1:0]   size_code;
  logic [2:0]   cond_sel;
  logic [15:0]  lane_mask;
  logic [15:0]  beat_mask;
  logic [3:0]   block_mask;
  logic [15:0]  pred_q;
  logic         illegal_q;
  logic         blk_start_q;
  logic [3:0]   blk_mask_q;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  vscmp_pred_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vec_in      (vec_in),
    .scalar_in   (scalar_in),
    .scalar_idx  (scalar_idx),
    .size_code   (size_code),
    .cond_sel    (cond_sel),
    .lane_mask   (lane_mask),
    .beat_mask   (beat_mask),
    .block_mask  (block_mask),
    .pred_q      (pred_q),
    .illegal_q   (illegal_q),
    .blk_start_q (blk_start_q),
    .blk_mask_q  (blk_mask_q)
  );

  localparam logic [127:0] VB = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] VH = 128'h8000_7fff_0001_0000_ffff_fffe_0002_0003;
  localparam logic [127:0] VW = 128'h80000000_7fffffff_00000010_ffffffff;

  // Conditions: EQ 000, NE 010, CS 001, HI 011, GE 100, LT 110, GT 101, LE 111
  typedef struct packed {
    logic [127:0] vec;
    logic [31:0]  sc;
    logic [1:0]   sz;
    logic [2:0]   cd;
    logic [15:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{VB, 32'h0000_0105, 2'd0, 3'b000, 16'h0020}, // R3 truncated byte
    '{VB, 32'h0000_ab0c, 2'd0, 3'b001, 16'hf000},
    '{VB, 32'h0000_000c, 2'd0, 3'b011, 16'he000},
    '{VB, 32'h0000_0005, 2'd0, 3'b010, 16'hffdf},
    '{VH, 32'h1234_0000, 2'd1, 3'b101, 16'h3c0f}, // R3 truncated half
    '{VH, 32'h0000_0000, 2'd1, 3'b110, 16'hc0f0},
    '{VH, 32'h0000_ffff, 2'd1, 3'b100, 16'h3fcf},
    '{VH, 32'h0000_0002, 2'd1, 3'b111, 16'hcffc},
    '{VH, 32'h0000_fffe, 2'd1, 3'b001, 16'h00f0},
    '{VW, 32'h0000_0010, 2'd2, 3'b011, 16'hff0f},
    '{VW, 32'h0000_0010, 2'd2, 3'b101, 16'h0f00},
    '{VW, 32'h0000_0010, 2'd2, 3'b110, 16'hf00f},
    '{VW, 32'h0000_0010, 2'd2, 3'b000, 16'h00f0},
    '{VW, 32'h8000_0000, 2'd2, 3'b111, 16'hf000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  task automatic do_req(input logic [127:0] v, input logic [31:0] sc, input logic [3:0] idx,
                        input logic [1:0] sz, input logic [2:0] cd, input logic [15:0] lm,
                        input logic [15:0] bm, input logic [3:0] blk);
    @(negedge clk);
    vec_in = v; scalar_in = sc; scalar_idx = idx; size_code = sz; cond_sel = cd;
    lane_mask = lm; beat_mask = bm; block_mask = blk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; vec_in = '0; scalar_in = '0; scalar_idx = '0;
    size_code = '0; cond_sel = '0; lane_mask = '1; beat_mask = '1; block_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 reset pred", pred_q, 16'h0000);
    check("R12 reset flags", {14'b0, illegal_q, blk_start_q}, 16'h0000);

    // R1 R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      do_req(TBL[i].vec, TBL[i].sc, 4'd0, TBL[i].sz, TBL[i].cd, 16'hffff, 16'hffff, 4'd0);
      check($sformatf("R1 R4 R5 table entry %0d", i), pred_q, TBL[i].exp);
    end

    // R8 index 15 forces zero scalar
    do_req(VB, 32'h0000_0005, 4'd15, 2'd0, 3'b000, 16'hffff, 16'hffff, 4'd0);
    check("R8 zero scalar", pred_q, 16'h0001);

    // preload all ones
    do_req(VB, 32'h0000_00ff, 4'd0, 2'd0, 3'b010, 16'hffff, 16'hffff, 4'd0);
    check("R4 preload NE", pred_q, 16'hffff);

    // R9 index 13 rejected
    do_req(VB, 32'h0000_0005, 4'd13, 2'd0, 3'b000, 16'hffff, 16'hffff, 4'd3);
    check("R9 pred kept", pred_q, 16'hffff);
    check("R9 illegal flag", {15'b0, illegal_q}, 16'h0001);
    check("R9 no block start", {15'b0, blk_start_q}, 16'h0000);
    @(negedge clk);
    check("R11 illegal pulse ends", {15'b0, illegal_q}, 16'h0000);

    // R2 size 3 rejected
    do_req(VB, 32'h0000_0005, 4'd0, 2'd3, 3'b000, 16'hffff, 16'hffff, 4'd0);
    check("R2 pred kept", pred_q, 16'hffff);
    check("R2 illegal flag", {15'b0, illegal_q}, 16'h0001);

    // R7 beat mask partial update
    do_req(VB, 32'h0000_0005, 4'd0, 2'd0, 3'b000, 16'hffff, 16'h00f0, 4'd0);
    check("R7 beat merge", pred_q, 16'hff2f);

    // R6 lane mask gating
    do_req(VB, 32'h0000_0005, 4'd0, 2'd0, 3'b010, 16'h00ff, 16'hffff, 4'd0);
    check("R6 lane gate", pred_q, 16'h00df);

    // R10 block start
    do_req(VB, 32'h0000_0005, 4'd0, 2'd0, 3'b000, 16'hffff, 16'hffff, 4'b1010);
    check("R10 pred", pred_q, 16'h0020);
    check("R10 strobe", {15'b0, blk_start_q}, 16'h0001);
    check("R10 mask", {12'b0, blk_mask_q}, 16'h000a);
    @(negedge clk);
    check("R11 strobe ends", {15'b0, blk_start_q}, 16'h0000);
    check("R11 idle hold", pred_q, 16'h0020);
    do_req(VB, 32'h0000_0006, 4'd0, 2'd0, 3'b000, 16'hffff, 16'hffff, 4'd0);
    check("R10 plain compare no strobe", {15'b0, blk_start_q}, 16'h0000);
    check("R11 registered result", pred_q, 16'h0040);

    // R12 reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 async clear", pred_q, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 held after release", pred_q, 16'h0000);

    finish_run();
  end

endmodule